// File: doc/BRIEF.md
# Return Address Stack with Checkpoint Repair

This block predicts the targets of subroutine returns for a fetch-stage branch predictor. Every hardware thread owns a separate circular stack of return addresses, chosen per cycle by a thread select input. On a predicted call the stack takes the call's PC plus the instruction size as a new entry. On a predicted return it offers its top entry as the target and then steps back by one slot.

Speculation can go wrong, so every read also exposes a checkpoint: the top index and the raw top value as they stood before the step back. When the pipeline later squashes the wrong path, it sends that checkpoint back on the restore port. The block then reloads the pointer and rewrites the slot, which repairs an entry that a wrong-path call overwrote. A separate undo command drops the latest push without reading it, for a call that was squashed or turned out not taken. The block carries out these commands but does not decide when to send them.

Top module: `ras_top`

## Requirements
- R1: After reset every thread's top index is 0, every entry is invalid and holds zero, so `retValid` is 0 and `retTarget` is 0 for any thread.
- R2: `retTarget` shows the selected thread's top entry whenever that entry is valid (`retValid`=1). When the entry is invalid, `retTarget` is 0 and `retValid` is 0.
- R3: `ckptIdx` and `ckptAddr` always show the selected thread's current top index and raw top value, before any command takes effect. A pop on its own moves the top index down by one.
- R4: A push on its own moves the top index to (index+1) mod DEPTH and writes pushPc+INST_BYTES there as a valid entry. `pushSlot` reports that slot in the same cycle. Once all DEPTH slots are used, a further push overwrites the oldest slot.
- R5: A push and a pop in the same cycle replace the top entry with pushPc+INST_BYTES and leave the top index unchanged. `pushSlot` then equals the current top index.
- R6: A restore sets the selected thread's top index to `restoreIdx` and writes `restoreAddr` into that slot as a valid entry.
- R7: A restore wins over a push, pop or undo in the same cycle. Only the restore takes effect.
- R8: An undo moves the top index down by one and writes nothing. A push or pop in the same cycle is ignored.
- R9: Commands change only the thread selected by `threadId`. Every other thread keeps its pointer and entries.
- R10: A pop or undo at top index 0 wraps the index to DEPTH-1 and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| threadId | input | TID_W | Thread whose stack is read and commanded |
| pushValid | input | 1 | Predicted call: push a return address |
| pushPc | input | ADDR_W | PC of the call |
| popValid | input | 1 | Predicted return: pop the top entry |
| undoValid | input | 1 | Drop the latest push without reading it |
| restoreValid | input | 1 | Repair from a checkpoint |
| restoreIdx | input | IDX_W | Checkpoint top index |
| restoreAddr | input | ADDR_W | Checkpoint top value |
| retValid | output | 1 | Top entry is valid |
| retTarget | output | ADDR_W | Predicted return target (0 when invalid) |
| ckptIdx | output | IDX_W | Top index before this cycle's command |
| ckptAddr | output | ADDR_W | Raw top value before this cycle's command |
| pushSlot | output | IDX_W | Slot a push in this cycle writes |

## Verification
Two kinds of same-cycle collision matter. The first is a restore landing together with a push, pop or undo. The second is a push and a pop arriving together. Directed steps set up each collision on a stack whose pointer and top value are already known. The following idle cycle then shows only the restore's index and value (R7), or an unchanged index with the new address on top (R5). The random phase sets all four command inputs on their own, with thread changes between cycles, so both collisions keep recurring. A bench model that applies the same priority order judges every cycle's outputs.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    WR_NEXT = 2'd0,
    WR_TOP  = 2'd1,
    WR_EXT  = 2'd2
  } wrSrc_e;

  typedef struct packed {
    logic   ptrLoad;
    logic   ptrInc;
    logic   ptrDec;
    logic   wrEn;
    wrSrc_e wrSrc;
  } rasStrobes_t;

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pushValid,
  input  logic        popValid,
  input  logic        undoValid,
  input  logic        restoreValid,
  output rasStrobes_t strb
);

  always_comb begin
    strb = '0;
    strb.wrSrc = WR_NEXT;
    if (restoreValid) begin
      strb.ptrLoad = 1'b1;
      strb.wrEn    = 1'b1;
      strb.wrSrc   = WR_EXT;
    end else if (undoValid) begin
      strb.ptrDec = 1'b1;
    end else if (pushValid && popValid) begin
      strb.wrEn  = 1'b1;
      strb.wrSrc = WR_TOP;
    end else if (pushValid) begin
      strb.ptrInc = 1'b1;
      strb.wrEn   = 1'b1;
    end else if (popValid) begin
      strb.ptrDec = 1'b1;
    end
  end

  // R8: an undo without restore never writes an entry
  a_r8_undo_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (undoValid && !restoreValid) |-> !strb.wrEn);

  // R7: a restore always takes the pointer, never steps it
  a_r7_restore_wins: assert property (@(posedge clk) disable iff (!rstN)
    restoreValid |-> (strb.ptrLoad && !strb.ptrInc && !strb.ptrDec));

endmodule

// File: rtl/ras_datapath.sv
module ras_datapath
  import ras_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 8,
  parameter int ADDR_W      = 32,
  parameter int INST_BYTES  = 4,
  localparam int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TID_W-1:0]  threadId,
  input  rasStrobes_t       strb,
  input  logic [ADDR_W-1:0] pushPc,
  input  logic [IDX_W-1:0]  restoreIdx,
  input  logic [ADDR_W-1:0] restoreAddr,
  output logic              retValid,
  output logic [ADDR_W-1:0] retTarget,
  output logic [IDX_W-1:0]  ckptIdx,
  output logic [ADDR_W-1:0] ckptAddr,
  output logic [IDX_W-1:0]  pushSlot
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  function automatic logic [IDX_W-1:0] stepUp(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] stepDown(input logic [IDX_W-1:0] i);
    return (i == '0) ? LAST_IDX : i - 1'b1;
  endfunction

  logic [IDX_W-1:0]  tosQ   [NUM_THREADS];
  logic [ADDR_W-1:0] entryQ [NUM_THREADS][DEPTH];
  logic              validQ [NUM_THREADS][DEPTH];

  logic [IDX_W-1:0]  curTos, nextSlot, wrIdx, newTos;
  logic [ADDR_W-1:0] wrData, topVal;
  logic              topVld;

  assign curTos   = tosQ[threadId];
  assign nextSlot = stepUp(curTos);
  assign topVal   = entryQ[threadId][curTos];
  assign topVld   = validQ[threadId][curTos];

  always_comb begin
    unique case (strb.wrSrc)
      WR_TOP:  wrIdx = curTos;
      WR_EXT:  wrIdx = restoreIdx;
      default: wrIdx = nextSlot;
    endcase
    wrData = (strb.wrSrc == WR_EXT) ? restoreAddr : pushPc + ADDR_W'(INST_BYTES);
    if (strb.ptrLoad)     newTos = restoreIdx;
    else if (strb.ptrInc) newTos = nextSlot;
    else if (strb.ptrDec) newTos = stepDown(curTos);
    else                  newTos = curTos;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        tosQ[t] <= '0;
        for (int d = 0; d < DEPTH; d++) begin
          entryQ[t][d] <= '0;
          validQ[t][d] <= 1'b0;
        end
      end
    end else begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (TID_W'(t) == threadId) begin
          tosQ[t] <= newTos;
          if (strb.wrEn) begin
            entryQ[t][wrIdx] <= wrData;
            validQ[t][wrIdx] <= 1'b1;
          end
        end
      end
    end
  end

  assign retValid  = topVld;
  assign retTarget = topVld ? topVal : '0;
  assign ckptIdx   = curTos;
  assign ckptAddr  = topVal;
  assign pushSlot  = (strb.wrSrc == WR_TOP) ? curTos : nextSlot;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : gChk
    // R6: restore loads the pointer and the slot value
    a_r6_restore_loads: assert property (@(posedge clk) disable iff (!rstN)
      (strb.ptrLoad && threadId == TID_W'(t)) |=>
        (tosQ[t] == $past(restoreIdx) && entryQ[t][tosQ[t]] == $past(restoreAddr)
         && validQ[t][tosQ[t]]));

    // R4: a plain push lands one slot up, valid, holding pc plus size
    a_r4_push_lands: assert property (@(posedge clk) disable iff (!rstN)
      (strb.ptrInc && threadId == TID_W'(t)) |=>
        (tosQ[t] == stepUp($past(tosQ[t])) && validQ[t][tosQ[t]]
         && entryQ[t][tosQ[t]] == $past(pushPc) + ADDR_W'(INST_BYTES)));

    // R3 / R10: a pop or undo steps the pointer down with wrap
    a_r10_step_down_wraps: assert property (@(posedge clk) disable iff (!rstN)
      (strb.ptrDec && threadId == TID_W'(t)) |=>
        (tosQ[t] == stepDown($past(tosQ[t]))));

    // R9: unselected threads keep their pointer
    a_r9_other_thread_stable: assert property (@(posedge clk) disable iff (!rstN)
      (threadId != TID_W'(t)) |=> $stable(tosQ[t]));
  end

endmodule

// File: rtl/ras_top.sv
module ras_top
  import ras_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 8,
  parameter int ADDR_W      = 32,
  parameter int INST_BYTES  = 4,
  localparam int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TID_W-1:0]  threadId,
  input  logic              pushValid,
  input  logic [ADDR_W-1:0] pushPc,
  input  logic              popValid,
  input  logic              undoValid,
  input  logic              restoreValid,
  input  logic [IDX_W-1:0]  restoreIdx,
  input  logic [ADDR_W-1:0] restoreAddr,
  output logic              retValid,
  output logic [ADDR_W-1:0] retTarget,
  output logic [IDX_W-1:0]  ckptIdx,
  output logic [ADDR_W-1:0] ckptAddr,
  output logic [IDX_W-1:0]  pushSlot
);

  rasStrobes_t strb;

  ras_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .popValid(popValid),
    .undoValid(undoValid), .restoreValid(restoreValid),
    .strb(strb)
  );

  ras_datapath #(
    .NUM_THREADS(NUM_THREADS), .DEPTH(DEPTH),
    .ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)
  ) uDp (
    .clk(clk), .rstN(rstN), .threadId(threadId), .strb(strb),
    .pushPc(pushPc), .restoreIdx(restoreIdx), .restoreAddr(restoreAddr),
    .retValid(retValid), .retTarget(retTarget),
    .ckptIdx(ckptIdx), .ckptAddr(ckptAddr), .pushSlot(pushSlot)
  );

  // R2: an invalid top never leaks a target
  a_r2_invalid_is_zero: assert property (@(posedge clk) disable iff (!rstN)
    !retValid |-> (retTarget == '0));

endmodule

// File: tb/tb_ras_top.sv
module tb_ras_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2;
  localparam int D  = 8;
  localparam int AW = 32;
  localparam int IB = 4;
  localparam int IW = 3;
  localparam int TW = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [TW-1:0] threadId = '0;
  logic pushValid = 0, popValid = 0, undoValid = 0, restoreValid = 0;
  logic [AW-1:0] pushPc = '0, restoreAddr = '0;
  logic [IW-1:0] restoreIdx = '0;
  logic retValid;
  logic [AW-1:0] retTarget, ckptAddr;
  logic [IW-1:0] ckptIdx, pushSlot;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [AW-1:0] mVal [NT][D];
  bit            mVld [NT][D];
  int            mTos [NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  ras_top #(.NUM_THREADS(NT), .DEPTH(D), .ADDR_W(AW), .INST_BYTES(IB)) dut (
    .clk(clk), .rstN(rstN), .threadId(threadId),
    .pushValid(pushValid), .pushPc(pushPc), .popValid(popValid),
    .undoValid(undoValid), .restoreValid(restoreValid),
    .restoreIdx(restoreIdx), .restoreAddr(restoreAddr),
    .retValid(retValid), .retTarget(retTarget),
    .ckptIdx(ckptIdx), .ckptAddr(ckptAddr), .pushSlot(pushSlot)
  );

  task automatic chk(input string tag, input string what, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int expPushSlot(int t, bit pu, bit po, bit un, bit rs);
    if (pu && po && !un && !rs) return mTos[t];
    return (mTos[t] + 1) % D;
  endfunction

  task automatic modelStep(int t, bit pu, logic [AW-1:0] pc, bit po, bit un, bit rs,
                           int ri, logic [AW-1:0] ra);
    if (rs) begin
      mTos[t] = ri; mVal[t][ri] = ra; mVld[t][ri] = 1;
    end else if (un) begin
      mTos[t] = (mTos[t] + D - 1) % D;
    end else if (pu && po) begin
      mVal[t][mTos[t]] = pc + IB; mVld[t][mTos[t]] = 1;
    end else if (pu) begin
      mTos[t] = (mTos[t] + 1) % D;
      mVal[t][mTos[t]] = pc + IB; mVld[t][mTos[t]] = 1;
    end else if (po) begin
      mTos[t] = (mTos[t] + D - 1) % D;
    end
  endtask

  // drive at negedge, compare combinational outputs, then let the edge commit
  task automatic apply(input string tag, input int t, input bit pu, input logic [AW-1:0] pc,
                       input bit po, input bit un, input bit rs, input int ri,
                       input logic [AW-1:0] ra);
    logic [AW-1:0] expTop;
    @(negedge clk);
    threadId = TW'(t); pushValid = pu; pushPc = pc; popValid = po;
    undoValid = un; restoreValid = rs; restoreIdx = IW'(ri); restoreAddr = ra;
    #1;
    expTop = mVld[t][mTos[t]] ? mVal[t][mTos[t]] : '0;
    chk(tag, "retValid", AW'(retValid), AW'(mVld[t][mTos[t]]));
    chk(tag, "retTarget", retTarget, expTop);
    chk(tag, "ckptIdx", AW'(ckptIdx), AW'(mTos[t]));
    chk(tag, "ckptAddr", ckptAddr, mVal[t][mTos[t]]);
    chk(tag, "pushSlot", AW'(pushSlot), AW'(expPushSlot(t, pu, po, un, rs)));
    modelStep(t, pu, pc, po, un, rs, ri, ra);
  endtask

  task automatic idle(input string tag, input int t);
    apply(tag, t, 0, '0, 0, 0, 0, 0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int t = 0; t < NT; t++) begin
      mTos[t] = 0;
      for (int d = 0; d < D; d++) begin mVal[t][d] = '0; mVld[t][d] = 0; end
    end
    seed = 32'h5EED_0A11;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state on both threads
    idle("R1", 0);
    idle("R1", 1);
    // R10: pop at index 0 wraps to DEPTH-1
    apply("R10", 1, 0, '0, 1, 0, 0, 0, '0);
    idle("R10", 1);
    // R4: fill thread 0 past its depth so the oldest slot is overwritten
    for (int i = 0; i < D + 1; i++) apply("R4", 0, 1, AW'(32'h1000 + i * 16), 0, 0, 0, 0, '0);
    idle("R4", 0);
    // R9: thread 1 untouched by thread 0 pushes
    idle("R9", 1);
    // R3: pops read and step back, through slot 0 into slot 7
    for (int i = 0; i < 3; i++) apply("R3", 0, 0, '0, 1, 0, 0, 0, '0);
    idle("R3", 0);
    // R5: push and pop together replace the top
    apply("R5", 0, 1, 32'h0000_BEE0, 1, 0, 0, 0, '0);
    idle("R5", 0);
    // R7: restore beats push, pop and undo
    apply("R7", 0, 1, 32'h0000_AAA0, 1, 1, 1, 5, 32'hCAFE_0005);
    idle("R7", 0);
    // R6: plain restore
    apply("R6", 0, 0, '0, 0, 0, 1, 2, 32'h0000_2222);
    idle("R6", 0);
    // R8: undo ignores a same-cycle push
    apply("R8", 0, 1, 32'h0000_DDD0, 0, 1, 0, 0, '0);
    idle("R8", 0);
    // R2: invalid top on thread 1 gives zero
    idle("R2", 1);

    // constrained random mix, R2 (target), R3 (checkpoint), R4 (slot)
    for (int n = 0; n < 3000; n++) begin
      int r;
      bit pu, po, un, rs;
      r  = $urandom % 100;
      pu = ($urandom % 100) < 40;
      po = ($urandom % 100) < 35;
      un = ($urandom % 100) < 8;
      rs = ($urandom % 100) < 8;
      apply(r < 50 ? "R2" : "R3", int'($urandom % NT), pu, $urandom & 32'hFFFF_FFFC,
            po, un, rs, int'($urandom % D), $urandom);
    end
    idle("R2", 0);
    idle("R2", 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule